// File: doc/BRIEF.md
# Prioritized Interrupt Controller With Halt Wake

This block arbitrates five interrupt sources for a small processor core. Each source has a request line that latches a flag bit, and an enable bit selects which flags count as pending. A master enable gates dispatch. When the core is running and the master enable is on, the lowest-numbered pending source is taken. Its flag is cleared, the master enable drops, and a dispatch window opens. During that window the entry address of the handler is presented to the core for a fixed number of cycles.

The block also tracks whether the core is running, halted or stopped. A halted core is woken by any enabled pending source. If the master enable is off at that moment, the core only resumes: nothing is dispatched and the flag stays set, so software can poll it. A stopped core is woken by any raw request line. While halted or stopped, an idle step pulse marks every fourth clock. Software reads and writes the enable and flag registers through a small register port.

Top module: `irq_arbiter`

## Requirements
- R1: A request pulse on source i sets flag bit i whether or not enable bit i is set; source i is pending only when both its flag and enable bits are set.
- R2: When several sources are pending, the one with the lowest index is serviced, and its handler address is 0x0040 + 8*i.
- R3: A dispatch is taken only in the run state with the master enable set; it clears the master enable and only the serviced flag bit, so no further dispatch follows until the master enable is set again.
- R4: `disp_valid` is high for exactly 5 consecutive cycles per dispatch with `disp_vec` stable, and no new dispatch starts until the window has closed.
- R5: Register select 1 addresses the flag register, whose bits 7:5 read as 1 and whose bits 4:0 a write replaces; select 0 addresses the enable register, whose bits 7:5 read as 0.
- R6: A request on a source in the same cycle that its flag is cleared by dispatch leaves the flag set.
- R7: In the halt state (`cpu_state` = 1), an enabled pending source returns the core to run (`cpu_state` = 0) with a one-cycle `wake` pulse and, if the master enable is set, dispatches in the same step; a flag whose enable bit is clear does not wake it.
- R8: When halt is left with the master enable clear, no dispatch occurs and the flag stays set.
- R9: In the halt or stop state, `idle_step` pulses once every 4 clocks, the first on the fourth cycle in that state; it stays low in run.
- R10: In the stop state (`cpu_state` = 2), only a raw request on any source line wakes the core, whatever the enable bits; a pending flag set by a register write does not.
- R11: `ime_clr` wins over `ime_set` in the same cycle, and a dispatch clears the master enable even if `ime_set` is high in that cycle.
- R12: After reset the flag register reads 0xE0 and the enable register reads 0x00. The state is run, and `disp_valid`, `wake` and `idle_step` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 5 | Request line per source |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects enable, 1 selects flag register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ime_set | input | 1 | Set master enable |
| ime_clr | input | 1 | Clear master enable |
| halt_req | input | 1 | Enter halt from run |
| stop_req | input | 1 | Enter stop from run |
| disp_valid | output | 1 | Dispatch window active |
| disp_vec | output | 16 | Handler address of current dispatch |
| wake | output | 1 | One-cycle pulse when halt or stop is left |
| idle_step | output | 1 | Pulse every fourth clock while halted or stopped |
| cpu_state | output | 2 | 0 run, 1 halt, 2 stop |

## Verification
The hardest cases to reach are the races between a dispatch and a port event in the same cycle. One is a request landing on the flag that is being cleared. Another is `ime_set` held high across the edge that takes a dispatch. The stimulus arms the master enable one cycle ahead, so the acceptance edge is known exactly, and drives the racing input at that edge. Halt wake-up is reached by entering halt with no pending flags and then raising a request. A disabled request is raised first to show it is ignored, and the master enable is set or cleared beforehand to take each wake-up path.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        CPU_RUN  = 2'd0,
        CPU_HALT = 2'd1,
        CPU_STOP = 2'd2
    } cpu_state_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int NSRC = 5,
    parameter int DW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            wr_en,
    input  logic            sel,
    input  logic [NSRC-1:0] wr_data,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] flag_o,
    output logic [DW-1:0]   rd_data
);
    localparam int PADW = DW - NSRC;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flag;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        if (wr_en && !sel) d.en = wr_data;
        if (wr_en && sel)  d.flag = wr_data;
        // dispatch clear first, then a fresh request re-sets the bit
        d.flag = (d.flag & ~clr_mask) | src_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign en_o    = q.en;
    assign flag_o  = q.flag;
    assign rd_data = sel ? {{PADW{1'b1}}, q.flag} : {{PADW{1'b0}}, q.en};

    // a request always lands in the flag on the next cycle
    p_req_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_req) |=> ((q.flag & $past(src_req)) == $past(src_req)));

    // without a flag write, a flag only falls where dispatch cleared it
    p_only_served_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel) |=> (($past(q.flag) & ~q.flag & ~$past(clr_mask)) == '0));

    // requests never disturb the enable register
    p_en_by_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q.en));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int NSRC = 5,
    parameter int IDXW = 3
) (
    input  logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] grant,
    output logic [IDXW-1:0] idx,
    output logic            any
);
    logic [NSRC:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign seen[i+1] = seen[i] | pend[i];
        assign grant[i]  = pend[i] & ~seen[i];
    end

    assign any = seen[NSRC];

    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/irq_core_fsm.sv
module irq_core_fsm
    import irq_pkg::*;
#(
    parameter int NSRC      = 5,
    parameter int IDXW      = 3,
    parameter int VW        = 16,
    parameter int VEC_BASE  = 'h40,
    parameter int VEC_STEP  = 8,
    parameter int DISP_CYC  = 5,
    parameter int IDLE_CYC  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pend_any,
    input  logic [NSRC-1:0] grant,
    input  logic [IDXW-1:0] grant_idx,
    input  logic            raw_any,
    input  logic            ime_set,
    input  logic            ime_clr,
    input  logic            halt_req,
    input  logic            stop_req,
    output logic [NSRC-1:0] clr_mask,
    output logic            disp_valid,
    output logic [VW-1:0]   disp_vec,
    output logic            wake,
    output logic            idle_step,
    output logic [1:0]      cpu_state
);
    localparam int CNTW = $clog2(DISP_CYC + 1);
    localparam int ICW  = (IDLE_CYC > 1) ? $clog2(IDLE_CYC) : 1;

    typedef struct packed {
        cpu_state_e      state;
        logic            ime;
        logic [CNTW-1:0] dcnt;
        logic [VW-1:0]   vec;
        logic            wake;
        logic [ICW-1:0]  icnt;
    } core_t;

    core_t q, d;
    logic  accept;
    logic  idle_win;
    logic [VW-1:0] idx_ext;

    assign idx_ext = VW'(grant_idx);

    always_comb begin
        d      = q;
        d.wake = 1'b0;
        accept = 1'b0;

        unique case (q.state)
            CPU_RUN: begin
                if (q.dcnt == '0) begin
                    if (q.ime && pend_any)  accept  = 1'b1;
                    else if (halt_req)      d.state = CPU_HALT;
                    else if (stop_req)      d.state = CPU_STOP;
                end
            end
            CPU_HALT: begin
                if (pend_any) begin
                    d.state = CPU_RUN;
                    d.wake  = 1'b1;
                    accept  = q.ime;
                end
            end
            CPU_STOP: begin
                if (raw_any) begin
                    d.state = CPU_RUN;
                    d.wake  = 1'b1;
                end
            end
            default: d.state = CPU_RUN;
        endcase

        if (ime_set) d.ime = 1'b1;
        if (ime_clr) d.ime = 1'b0;
        if (accept)  d.ime = 1'b0;

        if (accept) begin
            d.dcnt = CNTW'(DISP_CYC);
            d.vec  = VW'(VEC_BASE) + idx_ext * VW'(VEC_STEP);
        end else if (q.dcnt != '0) begin
            d.dcnt = q.dcnt - 1'b1;
        end

        if (q.state == CPU_RUN)               d.icnt = '0;
        else if (q.icnt == ICW'(IDLE_CYC - 1)) d.icnt = '0;
        else                                   d.icnt = q.icnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= CPU_RUN;
        end else begin
            q <= d;
        end
    end

    assign idle_win   = (q.state != CPU_RUN);
    assign clr_mask   = accept ? grant : '0;
    assign disp_valid = (q.dcnt != '0);
    assign disp_vec   = q.vec;
    assign wake       = q.wake;
    assign idle_step  = idle_win && (q.icnt == ICW'(IDLE_CYC - 1));
    assign cpu_state  = q.state;

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (pend_any == (grant != '0)));

    p_accept_drops_ime_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!q.ime && disp_valid));

    p_vec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.dcnt > CNTW'(1)) |=> ($stable(q.vec) && disp_valid));

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> !accept);

    p_halt_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == CPU_HALT && pend_any) |=> (q.state == CPU_RUN && q.wake));

    p_halt_no_ime_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == CPU_HALT && pend_any && !q.ime) |=> !disp_valid);

    p_stop_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == CPU_STOP && !raw_any) |=> (q.state == CPU_STOP));

    p_clr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ime_clr |=> !q.ime);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NSRC     = 5,
    parameter int DW       = 8,
    parameter int VW       = 16,
    parameter int VEC_BASE = 'h40,
    parameter int VEC_STEP = 8,
    parameter int DISP_CYC = 5,
    parameter int IDLE_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            reg_wr,
    input  logic            reg_sel,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            ime_set,
    input  logic            ime_clr,
    input  logic            halt_req,
    input  logic            stop_req,
    output logic            disp_valid,
    output logic [VW-1:0]   disp_vec,
    output logic            wake,
    output logic            idle_step,
    output logic [1:0]      cpu_state
);
    localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0] en_w, flag_w, pend_w, grant_w, clr_w;
    logic [IDXW-1:0] idx_w;
    logic            any_w;
    logic            unused_hi;

    assign unused_hi = ^reg_wdata[DW-1:NSRC];
    assign pend_w    = en_w & flag_w;

    irq_flag_bank #(.NSRC(NSRC), .DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (src_req),
        .wr_en    (reg_wr),
        .sel      (reg_sel),
        .wr_data  (reg_wdata[NSRC-1:0]),
        .clr_mask (clr_w),
        .en_o     (en_w),
        .flag_o   (flag_w),
        .rd_data  (reg_rdata)
    );

    irq_prio_enc #(.NSRC(NSRC), .IDXW(IDXW)) u_prio (
        .pend  (pend_w),
        .grant (grant_w),
        .idx   (idx_w),
        .any   (any_w)
    );

    irq_core_fsm #(
        .NSRC(NSRC), .IDXW(IDXW), .VW(VW), .VEC_BASE(VEC_BASE),
        .VEC_STEP(VEC_STEP), .DISP_CYC(DISP_CYC), .IDLE_CYC(IDLE_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_any   (any_w),
        .grant      (grant_w),
        .grant_idx  (idx_w),
        .raw_any    (|src_req),
        .ime_set    (ime_set),
        .ime_clr    (ime_clr),
        .halt_req   (halt_req),
        .stop_req   (stop_req),
        .clr_mask   (clr_w),
        .disp_valid (disp_valid),
        .disp_vec   (disp_vec),
        .wake       (wake),
        .idle_step  (idle_step),
        .cpu_state  (cpu_state)
    );
endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_req = '0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       ime_set = 1'b0, ime_clr = 1'b0, halt_req = 1'b0, stop_req = 1'b0;
    logic       disp_valid, wake, idle_step;
    logic [15:0] disp_vec;
    logic [1:0] cpu_state;

    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    irq_arbiter uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ime_set(ime_set), .ime_clr(ime_clr), .halt_req(halt_req),
        .stop_req(stop_req), .disp_valid(disp_valid), .disp_vec(disp_vec),
        .wake(wake), .idle_step(idle_step), .cpu_state(cpu_state)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] v);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic pulse_req(input logic [4:0] m);
        src_req = m;
        step();
        src_req = '0;
    endtask

    task automatic pulse_ime();
        ime_set = 1'b1;
        step();
        ime_set = 1'b0;
    endtask

    // check the rest of a window already seen once, then its close
    task automatic finish_window(input string req, input logic [15:0] v);
        for (int k = 0; k < 4; k++) begin
            step();
            chk(req, {disp_valid, disp_vec}, {1'b1, v});
        end
        step();
        chk(req, disp_valid, 1'b0);
    endtask

    task automatic t_reset();
        logic [7:0] r;
        rd_reg(1'b1, r); chk("R12 flag", r, 8'hE0);
        rd_reg(1'b0, r); chk("R12 en", r, 8'h00);
        chk("R12 outs", {disp_valid, wake, idle_step, cpu_state}, 5'b0);
    endtask

    task automatic t_regs();
        logic [7:0] r;
        pulse_req(5'b10100);
        rd_reg(1'b1, r); chk("R1 flag set while disabled", r, 8'hF4);
        chk("R1 no dispatch", disp_valid, 1'b0);
        wr_reg(1'b1, 8'h00); rd_reg(1'b1, r); chk("R5 flag clear", r, 8'hE0);
        wr_reg(1'b1, 8'hFF); rd_reg(1'b1, r); chk("R5 flag all", r, 8'hFF);
        wr_reg(1'b0, 8'hFF); rd_reg(1'b0, r); chk("R5 en upper zero", r, 8'h1F);
        wr_reg(1'b0, 8'h00); wr_reg(1'b1, 8'h00);
    endtask

    task automatic t_prio();
        logic [7:0] r;
        wr_reg(1'b0, 8'h1F);
        wr_reg(1'b1, 8'h16);
        ime_set = 1'b1; step(); ime_set = 1'b0;
        step();
        chk("R2 vec lowest", {disp_valid, disp_vec}, {1'b1, 16'h0048});
        rd_reg(1'b1, r); chk("R3 only served cleared", r, 8'hF4);
        ime_set = 1'b1; step(); ime_set = 1'b0;
        chk("R4 hold", {disp_valid, disp_vec}, {1'b1, 16'h0048});
        for (int k = 0; k < 3; k++) begin
            step(); chk("R4 hold", {disp_valid, disp_vec}, {1'b1, 16'h0048});
        end
        step(); chk("R4 window closes after 5", disp_valid, 1'b0);
        step(); chk("R4 next after gap", {disp_valid, disp_vec}, {1'b1, 16'h0050});
        finish_window("R4 second window", 16'h0050);
        for (int k = 0; k < 3; k++) begin
            step(); chk("R3 ime dropped", disp_valid, 1'b0);
        end
        pulse_ime();
        step(); chk("R2 vec 4", {disp_valid, disp_vec}, {1'b1, 16'h0060});
        finish_window("R4 third window", 16'h0060);
        rd_reg(1'b1, r); chk("R3 flags drained", r, 8'hE0);
    endtask

    task automatic t_ime_race();
        logic [7:0] r;
        wr_reg(1'b1, 8'h03);
        ime_set = 1'b1; step(); step(); ime_set = 1'b0;
        chk("R11 dispatch", {disp_valid, disp_vec}, {1'b1, 16'h0040});
        finish_window("R11 window", 16'h0040);
        for (int k = 0; k < 5; k++) begin
            step(); chk("R11 accept beats set", disp_valid, 1'b0);
        end
        rd_reg(1'b1, r); chk("R11 flag kept", r, 8'hE2);
        ime_set = 1'b1; ime_clr = 1'b1; step(); ime_set = 1'b0; ime_clr = 1'b0;
        for (int k = 0; k < 6; k++) begin
            step(); chk("R11 clr beats set", disp_valid, 1'b0);
        end
        wr_reg(1'b1, 8'h00);
    endtask

    task automatic t_req_race();
        logic [7:0] r;
        wr_reg(1'b1, 8'h01);
        ime_set = 1'b1; step(); ime_set = 1'b0;
        src_req = 5'b00001; step(); src_req = '0;
        chk("R6 dispatch", {disp_valid, disp_vec}, {1'b1, 16'h0040});
        rd_reg(1'b1, r); chk("R6 request wins", r, 8'hE1);
        finish_window("R6 window", 16'h0040);
        wr_reg(1'b1, 8'h00);
    endtask

    task automatic t_halt_ime();
        logic [7:0] r;
        wr_reg(1'b0, 8'h1D);
        pulse_ime();
        halt_req = 1'b1; step(); halt_req = 1'b0;
        chk("R7 halted", cpu_state, 2'd1);
        pulse_req(5'b00010);
        step(); step();
        chk("R7 disabled no wake", {cpu_state, wake}, {2'd1, 1'b0});
        rd_reg(1'b1, r); chk("R1 flag latched", r, 8'hE2);
        wr_reg(1'b1, 8'h00);
        pulse_req(5'b01000);
        step();
        chk("R7 wake+dispatch", {cpu_state, wake, disp_valid, disp_vec}, {2'd0, 1'b1, 1'b1, 16'h0058});
        rd_reg(1'b1, r); chk("R7 flag served", r, 8'hE0);
        step(); chk("R7 wake one cycle", wake, 1'b0);
        for (int k = 0; k < 4; k++) step();
        chk("R7 window over", disp_valid, 1'b0);
    endtask

    task automatic t_halt_noime();
        logic [7:0] r;
        ime_clr = 1'b1; step(); ime_clr = 1'b0;
        halt_req = 1'b1; step(); halt_req = 1'b0;
        pulse_req(5'b00100);
        step();
        chk("R8 wake no dispatch", {cpu_state, wake, disp_valid}, {2'd0, 1'b1, 1'b0});
        rd_reg(1'b1, r); chk("R8 flag stays", r, 8'hE4);
        step(); step();
        chk("R8 still none", disp_valid, 1'b0);
        wr_reg(1'b1, 8'h00);
    endtask

    task automatic t_idle();
        halt_req = 1'b1; step(); halt_req = 1'b0;
        for (int n = 1; n <= 12; n++) begin
            chk("R9 halt idle step", idle_step, (n % 4) == 0);
            step();
        end
        pulse_req(5'b00001);
        step();
        chk("R9 run state", cpu_state, 2'd0);
        for (int n = 0; n < 5; n++) begin
            chk("R9 low in run", idle_step, 1'b0);
            step();
        end
        wr_reg(1'b1, 8'h00);
    endtask

    task automatic t_stop();
        logic [7:0] r;
        stop_req = 1'b1; step(); stop_req = 1'b0;
        chk("R10 stopped", cpu_state, 2'd2);
        step(); step(); step();
        chk("R9 stop idle step", idle_step, 1'b1);
        wr_reg(1'b0, 8'h1F);
        wr_reg(1'b1, 8'h01);
        step(); step();
        chk("R10 pending ignored", {cpu_state, wake}, {2'd2, 1'b0});
        wr_reg(1'b0, 8'h00);
        wr_reg(1'b1, 8'h00);
        pulse_req(5'b10000);
        chk("R10 raw wakes", {cpu_state, wake}, {2'd0, 1'b1});
        rd_reg(1'b1, r); chk("R10 flag", r, 8'hF0);
        wr_reg(1'b1, 8'h00);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_regs();
        t_prio();
        t_ime_race();
        t_req_race();
        t_halt_ime();
        t_halt_noime();
        t_idle();
        t_stop();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog (all R): actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule